// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches page translations for a 39-bit virtual address space. Each entry holds a virtual page number and a physical page number. It also stores a page size level and the permission flags taken from a page-table entry. A lookup presents a virtual address, an access kind and a privilege flag. One cycle later the block answers with hit or miss, the physical address, and two separate fault flags. One flag reports page faults and the other reports physical-access faults. An external page-table walker refills one entry at a time. A fence port drops entries globally or for one address, and it can spare entries marked global.

The response path is a small state machine. Its states are `RSP_IDLE` (no lookup last cycle), `RSP_HIT` (exactly one entry matched), `RSP_MISS` (no entry matched) and `RSP_MULTI` (two or more entries matched). On every clock edge the state moves to `RSP_HIT`, `RSP_MISS` or `RSP_MULTI` if a lookup is presented, chosen by the number of matching entries. With no lookup it returns to `RSP_IDLE`. Entering `RSP_MULTI` also clears every entry.

Within one cycle, the entry valid bits are updated in this order: a multi-hit clear first, then the fence, then the refill. A refill in the same cycle as a fence or a multi-hit therefore survives. A lookup always sees the entries as they were before that clock edge.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` and `miss_pulse` are low, and the first lookup misses.
- R2: A lookup produces `rsp_valid` exactly one cycle later. The page-table entry layout is: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bit 4 user, bit 5 global, bit 6 accessed, bit 7 dirty, and the physical page number starting at bit 10. A 4 KiB hit returns that physical page number followed by the 12-bit page offset.
- R3: The level field selects the page size: 0 is a 1 GiB page, 1 is a 2 MiB page, and 2 is a 4 KiB page. A superpage matches on the top 9 or top 18 virtual page bits. The unmatched low virtual page bits pass through into the physical address.
- R4: `miss_pulse` is high for exactly one cycle, together with the response, for every lookup that misses, including a multi-hit. A response with `rsp_hit` low carries no fault flag.
- R5: If two or more entries match a lookup, the block reports a miss and invalidates every entry.
- R6: A fence without an address and with a zero address-space operand invalidates every entry. A fence with an address invalidates only the entries that the address matches, using the lookup match rule.
- R7: A fence with a non-zero address-space operand leaves entries marked global valid.
- R8: A refilled superpage whose low physical page bits are not zero (18 bits for level 0, 9 bits for level 1) hits with a page fault.
- R9: An entry refilled from an invalid page-table entry hits with a page fault and no access fault, even if the walker flagged an access error. A valid entry refilled with the walker access error hits with an access fault only.
- R10: The access kind is encoded as 0 for load, 1 for store and 2 for fetch. A hit raises a page fault in any of these cases: the accessed bit is clear; a store hits a page without write or without dirty; a load hits a page without read; a fetch hits a page without execute; the user flag differs from the page's user bit.
- R11: A refill takes the lowest-index invalid entry if one exists. Otherwise it takes the entry named by a round-robin pointer, which then advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 39 | Lookup virtual address |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_user | input | 1 | Request comes from user privilege |
| fill_valid | input | 1 | Refill request this cycle |
| fill_vpn | input | 27 | Virtual page number of the refill |
| fill_pte | input | PPN_W+10 | Page-table entry of the refill |
| fill_level | input | 2 | Page size level of the refill |
| fill_ae | input | 1 | Walker reported a physical-access error |
| fence_valid | input | 1 | Fence request this cycle |
| fence_use_va | input | 1 | Fence is limited to one address |
| fence_vaddr | input | 39 | Fence virtual address |
| fence_asid_nz | input | 1 | Fence carries a non-zero address-space operand |
| rsp_valid | output | 1 | Response for last cycle's lookup |
| rsp_hit | output | 1 | Exactly one entry matched |
| rsp_paddr | output | PPN_W+12 | Translated physical address |
| rsp_page_fault | output | 1 | Page fault on the hit |
| rsp_access_fault | output | 1 | Physical-access fault on the hit |
| miss_pulse | output | 1 | One-cycle event for a missed lookup |

## Verification
The bench builds the block with `ENTRIES` set to 4 and `PPN_W` set to 28. With only four entries, five refills are enough to exhaust the free slots. This brings the round-robin replacement and the invalid-first rule within reach, including the pointer wrap and a freed slot being refilled ahead of the pointer. A 28-bit physical page number is still wider than the 18 pass-through bits of a 1 GiB page. The superpage address composition and the misalignment faults are therefore exercised on a genuine mix of stored and passed-through bits.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W  = 39;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;

    localparam logic [1:0] KIND_LOAD  = 2'd0;
    localparam logic [1:0] KIND_STORE = 2'd1;
    localparam logic [1:0] KIND_FETCH = 2'd2;

    localparam logic [1:0] LVL_1G = 2'd0;
    localparam logic [1:0] LVL_2M = 2'd1;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_HIT,
        RSP_MISS,
        RSP_MULTI
    } rsp_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
        logic usr;
        logic glb;
        logic acc;
        logic dty;
    } perm_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  logic             ent_valid,
    input  logic [VPN_W-1:0] ent_vpn,
    input  logic [1:0]       ent_lvl,
    input  logic [VPN_W-1:0] probe_vpn,
    output logic             hit
);
    logic top_eq, mid_eq, low_eq;

    assign top_eq = ent_vpn[26:18] == probe_vpn[26:18];
    assign mid_eq = ent_vpn[17:9]  == probe_vpn[17:9];
    assign low_eq = ent_vpn[8:0]   == probe_vpn[8:0];

    always_comb begin
        unique case (ent_lvl)
            LVL_1G:  hit = ent_valid & top_eq;
            LVL_2M:  hit = ent_valid & top_eq & mid_eq;
            default: hit = ent_valid & top_eq & mid_eq & low_eq;
        endcase
    end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_pkg::*;
(
    input  perm_t      perm,
    input  logic [1:0] kind,
    input  logic       user,
    output logic       fault
);
    logic kind_bad;

    always_comb begin
        unique case (kind)
            KIND_STORE: kind_bad = !perm.wr | !perm.dty;
            KIND_FETCH: kind_bad = !perm.ex;
            default:    kind_bad = !perm.rd;
        endcase
    end

    assign fault = !perm.acc | kind_bad | (user != perm.usr);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               fill_fire,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign victim = any_free ? free_idx : rr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (fill_fire && !any_free) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int PPN_W   = 44,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int PTE_W  = PPN_W + 10,
    localparam int PA_W   = PPN_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [1:0]        lk_kind,
    input  logic              lk_user,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PTE_W-1:0]  fill_pte,
    input  logic [1:0]        fill_level,
    input  logic              fill_ae,
    input  logic              fence_valid,
    input  logic              fence_use_va,
    input  logic [VA_W-1:0]   fence_vaddr,
    input  logic              fence_asid_nz,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_page_fault,
    output logic              rsp_access_fault,
    output logic              miss_pulse
);
    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    logic [1:0]         lvl_q  [ENTRIES];
    perm_t              perm_q [ENTRIES];
    logic [ENTRIES-1:0] pf_q;
    logic [ENTRIES-1:0] ae_q;

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] fence_vec;
    logic [VPN_W-1:0]   lk_vpn;
    logic [VPN_W-1:0]   fc_vpn;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign fc_vpn = fence_vaddr[VA_W-1:OFF_W];

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_ent
            tlb_match u_lk_match (
                .ent_valid (valid_q[g]),
                .ent_vpn   (vpn_q[g]),
                .ent_lvl   (lvl_q[g]),
                .probe_vpn (lk_vpn),
                .hit       (hit_vec[g])
            );
            tlb_match u_fc_match (
                .ent_valid (valid_q[g]),
                .ent_vpn   (vpn_q[g]),
                .ent_lvl   (lvl_q[g]),
                .probe_vpn (fc_vpn),
                .hit       (fence_vec[g])
            );
        end
    endgenerate

    // refill decode
    logic [PPN_W-1:0] fill_ppn;
    perm_t            fill_perm;
    logic             fill_v, fill_misal, fill_pf;

    assign fill_ppn  = fill_pte[PTE_W-1:10];
    assign fill_v    = fill_pte[0];
    assign fill_perm = '{rd: fill_pte[1], wr: fill_pte[2], ex: fill_pte[3],
                         usr: fill_pte[4], glb: fill_pte[5], acc: fill_pte[6],
                         dty: fill_pte[7]};
    assign fill_misal = ((fill_level == LVL_1G) && (fill_ppn[17:0] != '0)) ||
                        ((fill_level == LVL_2M) && (fill_ppn[8:0]  != '0));
    assign fill_pf = !fill_v || (fill_perm.wr && !fill_perm.rd) ||
                     (!fill_perm.rd && !fill_perm.ex) || fill_misal;

    logic [IDX_W-1:0] victim;

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_q),
        .fill_fire (fill_valid),
        .victim    (victim)
    );

    // hit selection
    int unsigned      n_hit;
    logic             multi_hit, single_hit;
    logic [PPN_W-1:0] sel_ppn;
    logic [1:0]       sel_lvl;
    perm_t            sel_perm;
    logic             sel_pf, sel_ae, perm_fault;
    logic [PPN_W-1:0] lo_mask, out_ppn;

    assign n_hit      = $countones(hit_vec);
    assign multi_hit  = n_hit > 1;
    assign single_hit = n_hit == 1;

    always_comb begin
        sel_ppn  = '0;
        sel_lvl  = '0;
        sel_perm = '0;
        sel_pf   = 1'b0;
        sel_ae   = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                sel_ppn  = sel_ppn  | ppn_q[i];
                sel_lvl  = sel_lvl  | lvl_q[i];
                sel_perm = sel_perm | perm_q[i];
                sel_pf   = sel_pf   | pf_q[i];
                sel_ae   = sel_ae   | ae_q[i];
            end
        end
    end

    tlb_perm u_perm (
        .perm  (sel_perm),
        .kind  (lk_kind),
        .user  (lk_user),
        .fault (perm_fault)
    );

    always_comb begin
        unique case (sel_lvl)
            LVL_1G:  lo_mask = PPN_W'(18'h3FFFF);
            LVL_2M:  lo_mask = PPN_W'(9'h1FF);
            default: lo_mask = '0;
        endcase
        out_ppn = (sel_ppn & ~lo_mask) | (PPN_W'(lk_vpn[17:0]) & lo_mask);
    end

    // entry valid bits: multi-hit clear, then fence, then refill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                logic v;
                v = valid_q[i];
                if (lk_valid && multi_hit) begin
                    v = 1'b0;
                end
                if (fence_valid && (!fence_use_va || fence_vec[i]) &&
                    !(fence_asid_nz && perm_q[i].glb)) begin
                    v = 1'b0;
                end
                if (fill_valid && (victim == IDX_W'(i))) begin
                    v = 1'b1;
                end
                valid_q[i] <= v;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_valid) begin
            vpn_q[victim]  <= fill_vpn;
            ppn_q[victim]  <= fill_ppn;
            lvl_q[victim]  <= fill_level;
            perm_q[victim] <= fill_perm;
            pf_q[victim]   <= fill_pf;
            ae_q[victim]   <= fill_ae && fill_v && !fill_pf;
        end
    end

    // response state machine
    rsp_state_e       state_q, state_d;
    logic [PA_W-1:0]  paddr_q;
    logic             rpf_q, rae_q;

    always_comb begin
        if (!lk_valid)        state_d = RSP_IDLE;
        else if (multi_hit)   state_d = RSP_MULTI;
        else if (single_hit)  state_d = RSP_HIT;
        else                  state_d = RSP_MISS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paddr_q <= '0;
            rpf_q   <= 1'b0;
            rae_q   <= 1'b0;
        end else if (lk_valid) begin
            paddr_q <= {out_ppn, lk_vaddr[OFF_W-1:0]};
            rpf_q   <= single_hit && (sel_pf || (!sel_ae && perm_fault));
            rae_q   <= single_hit && !sel_pf && sel_ae;
        end
    end

    always_comb begin
        rsp_valid        = 1'b0;
        rsp_hit          = 1'b0;
        miss_pulse       = 1'b0;
        rsp_paddr        = paddr_q;
        rsp_page_fault   = 1'b0;
        rsp_access_fault = 1'b0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_HIT: begin
                rsp_valid        = 1'b1;
                rsp_hit          = 1'b1;
                rsp_page_fault   = rpf_q;
                rsp_access_fault = rae_q;
            end
            RSP_MISS, RSP_MULTI: begin
                rsp_valid  = 1'b1;
                miss_pulse = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
    parameter int ENTRIES = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               fill_valid,
    input logic               fence_valid,
    input logic               fence_use_va,
    input logic               fence_asid_nz,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_page_fault,
    input logic               rsp_access_fault,
    input logic               miss_pulse,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [ENTRIES-1:0] valid_q
);
    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    a_r4_pulse_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        miss_pulse |-> (rsp_valid && !rsp_hit));

    a_r4_miss_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (!rsp_page_fault && !rsp_access_fault));

    a_r9_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_page_fault && rsp_access_fault));

    a_r5_multi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && ($countones(hit_vec) > 1) && !fill_valid) |=> (valid_q == '0));

    a_r6_global_fence: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_valid && !fence_use_va && !fence_asid_nz && !fill_valid) |=> (valid_q == '0));

    a_r11_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (valid_q != '0));
endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .lk_valid         (lk_valid),
    .fill_valid       (fill_valid),
    .fence_valid      (fence_valid),
    .fence_use_va     (fence_use_va),
    .fence_asid_nz    (fence_asid_nz),
    .rsp_valid        (rsp_valid),
    .rsp_hit          (rsp_hit),
    .rsp_page_fault   (rsp_page_fault),
    .rsp_access_fault (rsp_access_fault),
    .miss_pulse       (miss_pulse),
    .hit_vec          (hit_vec),
    .valid_q          (valid_q)
);

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES = 4;
    localparam int PPN_W   = 28;
    localparam int PTE_W   = PPN_W + 10;
    localparam int PA_W    = PPN_W + 12;

    localparam logic [7:0] F_V = 8'h01, F_R = 8'h02, F_W = 8'h04, F_X = 8'h08;
    localparam logic [7:0] F_U = 8'h10, F_G = 8'h20, F_A = 8'h40, F_D = 8'h80;
    localparam logic [7:0] F_ALL = F_V | F_R | F_W | F_X | F_A | F_D;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0;
    logic [38:0]      lk_vaddr = '0;
    logic [1:0]       lk_kind = '0;
    logic             lk_user = 1'b0;
    logic             fill_valid = 1'b0;
    logic [26:0]      fill_vpn = '0;
    logic [PTE_W-1:0] fill_pte = '0;
    logic [1:0]       fill_level = '0;
    logic             fill_ae = 1'b0;
    logic             fence_valid = 1'b0;
    logic             fence_use_va = 1'b0;
    logic [38:0]      fence_vaddr = '0;
    logic             fence_asid_nz = 1'b0;
    logic             rsp_valid, rsp_hit, rsp_page_fault, rsp_access_fault, miss_pulse;
    logic [PA_W-1:0]  rsp_paddr;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_fa #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .lk_valid (lk_valid), .lk_vaddr (lk_vaddr), .lk_kind (lk_kind), .lk_user (lk_user),
        .fill_valid (fill_valid), .fill_vpn (fill_vpn), .fill_pte (fill_pte),
        .fill_level (fill_level), .fill_ae (fill_ae),
        .fence_valid (fence_valid), .fence_use_va (fence_use_va),
        .fence_vaddr (fence_vaddr), .fence_asid_nz (fence_asid_nz),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_paddr (rsp_paddr),
        .rsp_page_fault (rsp_page_fault), .rsp_access_fault (rsp_access_fault),
        .miss_pulse (miss_pulse)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [26:0] vpn, input logic [PPN_W-1:0] ppn,
                        input logic [7:0] flags, input logic [1:0] lvl, input logic ae);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_pte = {ppn, 2'b00, flags};
        fill_level = lvl; fill_ae = ae;
        @(negedge clk);
        fill_valid = 1'b0; fill_ae = 1'b0;
    endtask

    task automatic fence(input logic use_va, input logic [26:0] vpn, input logic asid_nz);
        @(negedge clk);
        fence_valid = 1'b1; fence_use_va = use_va;
        fence_vaddr = {vpn, 12'h000}; fence_asid_nz = asid_nz;
        @(negedge clk);
        fence_valid = 1'b0;
    endtask

    // leaves outputs of the registered response visible at the returning negedge
    task automatic lookup(input logic [26:0] vpn, input logic [11:0] off,
                          input logic [1:0] kind, input logic user);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_kind = kind; lk_user = user;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [26:0] vpn, input logic user);
        lookup(vpn, 12'h0, 2'd0, user);
        chk(req, rsp_hit, 1'b1);
    endtask

    task automatic expect_miss(input string req, input logic [26:0] vpn);
        lookup(vpn, 12'h0, 2'd0, 1'b0);
        chk(req, {rsp_valid, rsp_hit}, 2'b10);
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid after reset", rsp_valid, 1'b0);
        chk("R1 miss_pulse after reset", miss_pulse, 1'b0);
        lookup(27'h0000123, 12'h0, 2'd0, 1'b0);
        chk("R1 first lookup misses", {rsp_valid, rsp_hit, miss_pulse}, 3'b101);
    endtask

    task automatic t_basic();
        fence(1'b0, '0, 1'b0);
        fill(27'h0001234, 28'h00ABCDE, F_ALL, 2'd2, 1'b0);
        lookup(27'h0001234, 12'h5A6, 2'd0, 1'b0);
        chk("R2 4K hit", {rsp_valid, rsp_hit, miss_pulse}, 3'b110);
        chk("R2 4K paddr", rsp_paddr, {28'h00ABCDE, 12'h5A6});
        chk("R2 4K no fault", {rsp_page_fault, rsp_access_fault}, 2'b00);
        lookup(27'h0001235, 12'h0, 2'd0, 1'b0);
        chk("R4 miss pulse", {rsp_hit, miss_pulse}, 2'b01);
        chk("R4 miss no fault", {rsp_page_fault, rsp_access_fault}, 2'b00);
        @(negedge clk);
        chk("R4 pulse lasts one cycle", {rsp_valid, miss_pulse}, 2'b00);
    endtask

    task automatic t_super();
        logic [PPN_W-1:0] exp_ppn;
        fence(1'b0, '0, 1'b0);
        fill({9'd3, 9'd5, 9'd0}, 28'h0246800, F_ALL, 2'd1, 1'b0);
        fill({9'd7, 18'd0}, 28'h0AC0000, F_ALL, 2'd0, 1'b0);
        lookup({9'd3, 9'd5, 9'h1AB}, 12'h123, 2'd0, 1'b0);
        exp_ppn = 28'h0246800 | 28'h00001AB;
        chk("R3 2M hit", rsp_hit, 1'b1);
        chk("R3 2M paddr", rsp_paddr, {exp_ppn, 12'h123});
        lookup({9'd7, 18'h2ABCD}, 12'hFED, 2'd0, 1'b0);
        exp_ppn = 28'h0AC0000 | 28'h002ABCD;
        chk("R3 1G hit", rsp_hit, 1'b1);
        chk("R3 1G paddr", rsp_paddr, {exp_ppn, 12'hFED});
        expect_miss("R3 2M other region misses", {9'd3, 9'd6, 9'h1AB});
    endtask

    task automatic t_perm();
        fence(1'b0, '0, 1'b0);
        fill(27'h0000010, 28'h10, F_V | F_R | F_A, 2'd2, 1'b0);
        fill(27'h0000020, 28'h20, F_V | F_R | F_W | F_A, 2'd2, 1'b0);
        fill(27'h0000030, 28'h30, F_ALL | F_U, 2'd2, 1'b0);
        lookup(27'h0000010, 12'h0, 2'd1, 1'b0);
        chk("R10 store to read-only", {rsp_hit, rsp_page_fault}, 2'b11);
        lookup(27'h0000010, 12'h0, 2'd0, 1'b0);
        chk("R10 load to readable", {rsp_hit, rsp_page_fault}, 2'b10);
        lookup(27'h0000020, 12'h0, 2'd1, 1'b0);
        chk("R10 store to clean page", {rsp_hit, rsp_page_fault}, 2'b11);
        lookup(27'h0000020, 12'h0, 2'd2, 1'b0);
        chk("R10 fetch without execute", {rsp_hit, rsp_page_fault}, 2'b11);
        lookup(27'h0000030, 12'h0, 2'd0, 1'b0);
        chk("R10 supervisor on user page", {rsp_hit, rsp_page_fault}, 2'b11);
        lookup(27'h0000030, 12'h0, 2'd1, 1'b1);
        chk("R10 user store on user page", {rsp_hit, rsp_page_fault}, 2'b10);
        fill(27'h0000040, 28'h40, F_V | F_R | F_W | F_X | F_D, 2'd2, 1'b0);
        lookup(27'h0000040, 12'h0, 2'd0, 1'b0);
        chk("R10 accessed clear", {rsp_hit, rsp_page_fault}, 2'b11);
    endtask

    task automatic t_fault();
        fence(1'b0, '0, 1'b0);
        fill({9'd1, 9'd2, 9'd0}, 28'h0000001, F_ALL, 2'd1, 1'b0);
        lookup({9'd1, 9'd2, 9'd4}, 12'h0, 2'd0, 1'b0);
        chk("R8 misaligned 2M", {rsp_hit, rsp_page_fault, rsp_access_fault}, 3'b110);
        fill(27'h0000050, 28'h50, 8'h00, 2'd2, 1'b1);
        lookup(27'h0000050, 12'h0, 2'd0, 1'b0);
        chk("R9 invalid pte", {rsp_hit, rsp_page_fault, rsp_access_fault}, 3'b110);
        fill(27'h0000060, 28'h60, F_ALL, 2'd2, 1'b1);
        lookup(27'h0000060, 12'h0, 2'd0, 1'b0);
        chk("R9 walker access error", {rsp_hit, rsp_page_fault, rsp_access_fault}, 3'b101);
        fill({9'd2, 18'd0}, 28'h0001000, F_ALL, 2'd0, 1'b0);
        lookup({9'd2, 18'd9}, 12'h0, 2'd0, 1'b0);
        chk("R8 misaligned 1G", {rsp_hit, rsp_page_fault}, 2'b11);
    endtask

    task automatic t_multi();
        fence(1'b0, '0, 1'b0);
        fill({9'd4, 9'd4, 9'd4}, 28'h70, F_ALL, 2'd2, 1'b0);
        fill({9'd4, 9'd4, 9'd0}, 28'h0000200, F_ALL, 2'd1, 1'b0);
        fill(27'h0000080, 28'h80, F_ALL, 2'd2, 1'b0);
        lookup({9'd4, 9'd4, 9'd4}, 12'h0, 2'd0, 1'b0);
        chk("R5 multi-hit reports miss", {rsp_valid, rsp_hit, miss_pulse}, 3'b101);
        expect_miss("R5 unrelated entry cleared", 27'h0000080);
    endtask

    task automatic t_fence();
        fence(1'b0, '0, 1'b0);
        fill(27'h0000090, 28'h90, F_ALL, 2'd2, 1'b0);
        fill(27'h00000A0, 28'hA0, F_ALL | F_G, 2'd2, 1'b0);
        fence(1'b1, 27'h0000090, 1'b0);
        expect_miss("R6 fenced address gone", 27'h0000090);
        expect_hit("R6 other address kept", 27'h00000A0, 1'b0);
        fill(27'h0000090, 28'h90, F_ALL, 2'd2, 1'b0);
        fence(1'b0, '0, 1'b1);
        expect_miss("R7 non-global dropped", 27'h0000090);
        expect_hit("R7 global kept", 27'h00000A0, 1'b0);
        fence(1'b0, '0, 1'b0);
        expect_miss("R6 global fence drops global", 27'h00000A0);
    endtask

    task automatic t_rr();
        fence(1'b0, '0, 1'b0);
        for (int i = 0; i < 4; i++) fill(27'h100 + 27'(i), 28'h100 + 28'(i), F_ALL, 2'd2, 1'b0);
        fill(27'h104, 28'h104, F_ALL, 2'd2, 1'b0);
        expect_miss("R11 first victim is entry 0", 27'h100);
        expect_hit("R11 entry 1 kept", 27'h101, 1'b0);
        fill(27'h105, 28'h105, F_ALL, 2'd2, 1'b0);
        expect_miss("R11 pointer advanced", 27'h101);
        fence(1'b1, 27'h103, 1'b0);
        fill(27'h106, 28'h106, F_ALL, 2'd2, 1'b0);
        expect_hit("R11 invalid slot used first", 27'h102, 1'b0);
        expect_hit("R11 new entry present", 27'h106, 1'b0);
        expect_hit("R11 earlier refill kept", 27'h104, 1'b0);
        expect_hit("R11 second refill kept", 27'h105, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_super();
        t_perm();
        t_fault();
        t_multi();
        t_fence();
        t_rr();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule